// File: doc/BRIEF.md
# I2C Receive Interlock Clock Stretcher

This block sits between the byte-assembly logic of an I2C master and slave and the software-visible receive registers. Each of the two channels, master and slave, has its own receive data register and ready flag. When a byte completes and the flag is clear, the byte goes into the data register and the flag is set. Software reads the byte and then clears the flag.

A second byte can complete before software has cleared the flag. In that case the block does not report an overrun. It keeps the new byte in a private pending register and asserts a pull-low request on SCL, which stalls the bus. When software clears the flag, the pending byte moves into the data register, the flag stays set, and SCL is released. One interrupt line covers both channels. It is the OR of each channel's ready flag gated by that channel's enable.

Top module: `i2c_rx_interlock`

## Requirements
- R1: When a channel completes a byte while its ready flag is 0 and nothing is pending, from the next cycle its data output equals that byte and its ready flag is 1.
- R2: A clear while the flag is 1 and nothing is pending drops the flag to 0 on the next cycle and leaves the data output unchanged.
- R3: A byte completion while the flag is 1 and no clear is present leaves the data output unchanged and raises `scl_hold` from the next cycle.
- R4: Once stalled, `scl_hold` stays 1 on every cycle until the channel is cleared. Further byte completions during the stall are ignored, and the first pending byte is kept.
- R5: A clear during a stall makes, from the next cycle, the data output equal to the pending byte, the flag 1 and `scl_hold` 0.
- R6: A clear and a byte completion in the same cycle with nothing pending load the new byte directly. The flag stays 1 and `scl_hold` stays 0.
- R7: A clear while the flag is 0 has no effect on the flag or the data output.
- R8: `irq` is 1 in the same cycle exactly when some channel has both its ready flag and its enable input at 1.
- R9: The master and slave channels are independent. `scl_hold` is 1 while either channel is stalled.
- R10: After reset both flags are 0, both data outputs are 0, `scl_hold` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_byte_done | input | 1 | Master byte completed this cycle |
| m_byte_in | input | DW | Master completed byte |
| m_clear | input | 1 | Software clear of master ready flag |
| m_irq_en | input | 1 | Master interrupt enable |
| s_byte_done | input | 1 | Slave byte completed this cycle |
| s_byte_in | input | DW | Slave completed byte |
| s_clear | input | 1 | Software clear of slave ready flag |
| s_irq_en | input | 1 | Slave interrupt enable |
| m_rx_data | output | DW | Master receive data register |
| m_ready | output | 1 | Master data-ready flag |
| s_rx_data | output | DW | Slave receive data register |
| s_ready | output | 1 | Slave data-ready flag |
| scl_hold | output | 1 | Request to pull SCL low (stall) |
| irq | output | 1 | Merged interrupt |

## Verification
Every registered result (data outputs, ready flags, `scl_hold`) is due one clock edge after the cycle that presents the stimulus. `irq` follows the flags and enables combinationally within that same cycle. The bench drives inputs shortly after a rising edge, waits for the next rising edge, and samples one time unit later, so each check observes exactly the first cycle in which a result should appear. Stall checks repeat that sample over several idle cycles to confirm that the hold never drops.

// File: rtl/i2c_rx_interlock.sv
module i2c_rx_interlock #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_byte_done,
  input  logic [DW-1:0] m_byte_in,
  input  logic          m_clear,
  input  logic          m_irq_en,
  input  logic          s_byte_done,
  input  logic [DW-1:0] s_byte_in,
  input  logic          s_clear,
  input  logic          s_irq_en,
  output logic [DW-1:0] m_rx_data,
  output logic          m_ready,
  output logic [DW-1:0] s_rx_data,
  output logic          s_ready,
  output logic          scl_hold,
  output logic          irq
);
  localparam int NCH = 2;

  logic [NCH-1:0] done, clr, ien, rdy, pnd;
  logic [DW-1:0]  din  [NCH];
  logic [DW-1:0]  dat  [NCH];
  logic [DW-1:0]  pbuf [NCH];

  assign done   = {s_byte_done, m_byte_done};
  assign clr    = {s_clear, m_clear};
  assign ien    = {s_irq_en, m_irq_en};
  assign din[0] = m_byte_in;
  assign din[1] = s_byte_in;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dat[ch]  <= '0;
        pbuf[ch] <= '0;
        rdy[ch]  <= 1'b0;
        pnd[ch]  <= 1'b0;
      end else if (pnd[ch]) begin
        if (clr[ch]) begin
          dat[ch] <= pbuf[ch];
          pnd[ch] <= 1'b0;
        end
      end else if (done[ch] && (!rdy[ch] || clr[ch])) begin
        dat[ch] <= din[ch];
        rdy[ch] <= 1'b1;
      end else if (done[ch]) begin
        pbuf[ch] <= din[ch];
        pnd[ch]  <= 1'b1;
      end else if (clr[ch]) begin
        rdy[ch] <= 1'b0;
      end
    end

    AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done[ch] && !rdy[ch] && !pnd[ch] |=> rdy[ch] && dat[ch] == $past(din[ch])); // R1
    AST_UNREAD_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rdy[ch] && !clr[ch] |=> $stable(dat[ch])); // R3
    AST_PEND_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pnd[ch] |-> rdy[ch]); // R4
    AST_STALL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      pnd[ch] && !clr[ch] |=> pnd[ch] && $stable(pbuf[ch])); // R4
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      pnd[ch] && clr[ch] |=> rdy[ch] && !pnd[ch]); // R5
    AST_IDLE_CLEAR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy[ch] && !done[ch] |=> !rdy[ch] && $stable(dat[ch])); // R7
  end

  assign m_rx_data = dat[0];
  assign s_rx_data = dat[1];
  assign m_ready   = rdy[0];
  assign s_ready   = rdy[1];
  assign scl_hold  = |pnd;
  assign irq       = |(rdy & ien);

endmodule

// File: tb/tb_i2c_rx_interlock.sv
module tb_i2c_rx_interlock;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic md = 0, mc = 0, me = 0, sd = 0, sc = 0, se = 0;
  logic [DW-1:0] mb = '0, sb = '0;
  logic [DW-1:0] m_rx_data, s_rx_data;
  logic m_ready, s_ready, scl_hold, irq;
  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  i2c_rx_interlock #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .m_byte_done(md), .m_byte_in(mb), .m_clear(mc), .m_irq_en(me),
    .s_byte_done(sd), .s_byte_in(sb), .s_clear(sc), .s_irq_en(se),
    .m_rx_data(m_rx_data), .m_ready(m_ready),
    .s_rx_data(s_rx_data), .s_ready(s_ready),
    .scl_hold(scl_hold), .irq(irq));

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic d_m, logic [DW-1:0] b_m, logic c_m,
                      logic d_s, logic [DW-1:0] b_s, logic c_s);
    md = d_m; mb = b_m; mc = c_m; sd = d_s; sb = b_s; sc = c_s;
    @(posedge clk); #1;
    md = 0; mc = 0; sd = 0; sc = 0;
  endtask

  task automatic idle(); step(0, '0, 0, 0, '0, 0); endtask

  initial begin
    #400000;
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    me = 1; se = 1;
    cmp("R10 m_ready", m_ready, 0);
    cmp("R10 s_ready", s_ready, 0);
    cmp("R10 data", {m_rx_data, s_rx_data}, 0);
    cmp("R10 scl_hold", scl_hold, 0);
    cmp("R10 irq", irq, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R7: clear on an empty channel
    step(0, '0, 1, 0, '0, 1);
    cmp("R7 m_ready", m_ready, 0);
    cmp("R7 m_data", m_rx_data, 0);
    cmp("R7 s_ready", s_ready, 0);

    for (int i = 0; i < 256; i += 15) begin
      logic [DW-1:0] b1, b2, b3;
      b1 = DW'(i); b2 = DW'(i * 7 + 3); b3 = ~b1;
      // R1
      step(1, b1, 0, 0, '0, 0);
      cmp("R1 m_data", m_rx_data, b1);
      cmp("R1 m_ready", m_ready, 1);
      cmp("R9 s_ready idle", s_ready, 0);
      // R3
      step(1, b2, 0, 0, '0, 0);
      cmp("R3 m_data kept", m_rx_data, b1);
      cmp("R3 scl_hold", scl_hold, 1);
      // R4
      step(1, b3, 0, 0, '0, 0);
      for (int k = 0; k < 3; k++) begin
        cmp("R4 scl_hold", scl_hold, 1);
        cmp("R4 m_data", m_rx_data, b1);
        idle();
      end
      // R5
      step(0, '0, 1, 0, '0, 0);
      cmp("R5 m_data", m_rx_data, b2);
      cmp("R5 m_ready", m_ready, 1);
      cmp("R5 scl_hold", scl_hold, 0);
      // R6
      step(1, b3, 1, 0, '0, 0);
      cmp("R6 m_data", m_rx_data, b3);
      cmp("R6 m_ready", m_ready, 1);
      cmp("R6 scl_hold", scl_hold, 0);
      // R2
      step(0, '0, 1, 0, '0, 0);
      cmp("R2 m_ready", m_ready, 0);
      cmp("R2 m_data", m_rx_data, b3);

      // R9: slave stall while master loads and clears
      step(1, b2, 0, 1, b1, 0);
      step(0, '0, 0, 1, b2, 0);
      cmp("R9 scl_hold slave", scl_hold, 1);
      cmp("R9 m_data", m_rx_data, b2);
      cmp("R9 s_data", s_rx_data, b1);
      step(0, '0, 1, 0, '0, 0);
      cmp("R9 m_ready cleared", m_ready, 0);
      cmp("R9 hold kept", scl_hold, 1);
      step(0, '0, 0, 0, '0, 1);
      cmp("R5 s_data", s_rx_data, b2);
      cmp("R9 hold released", scl_hold, 0);
      step(0, '0, 0, 0, '0, 1);
      cmp("R2 s_ready", s_ready, 0);
    end

    // R8: sweep flags x enables
    for (int v = 0; v < 16; v++) begin
      logic fm, fs;
      fm = v[0]; fs = v[1]; me = v[2]; se = v[3];
      step(fm, 8'h5A, !fm && m_ready, fs, 8'hA5, !fs && s_ready);
      cmp("R8 irq", irq, (fm & v[2]) | (fs & v[3]));
      step(0, '0, m_ready, 0, '0, s_ready);
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule